// File: doc/BRIEF.md
# Dual-channel averaging level monitor with crossing interrupt

This block sits behind an auxiliary ADC and watches two analog levels, for example a received signal strength used as a carrier detector. Each channel keeps its own running average, updated on each valid sample. The weight of the new sample is set by a 3-bit depth code. A larger code gives a slower and smoother average.

After each update, the channel compares the new average against its own high threshold. A small state machine per channel has two states, BELOW and ABOVE. The transition RISE goes from BELOW to ABOVE. It happens on a sample whose average is strictly greater than the threshold, and it sets a sticky interrupt flag. The transition FALL goes from ABOVE to BELOW. It happens on a sample whose average is at or below the threshold, and it raises no interrupt. In every other case the state holds. Software clears the interrupt with a write-one-to-clear strobe.

Each channel also presents a 16-bit readback word. The word holds the current average together with the threshold state.

Top module: `adcmon_top`

## Requirements
- R1: After reset, both readback words are 0 and both interrupt outputs are 0. The state is BELOW and the average is 0.
- R2: A sample taken with depth code 0 replaces the average outright.
- R3: A sample taken with depth code n, for n from 1 to 5, sets the average to avg + floor((sample - avg) / 2^n). The new sample therefore carries weight 1/2^n.
- R4: Depth codes 6 and 7 give the same result as code 5.
- R5: The readback word is laid out as follows. Bit 15 is the threshold state, 1 when the channel is in ABOVE. Bits 9:0 are the average. Bits 14:10 are always 0.
- R6: The RISE transition sets the interrupt output one clock after the sample strobe. RISE requires a sample whose new average is strictly greater than the threshold while the channel is in BELOW.
- R7: An average equal to the threshold counts as not above. Further samples above the threshold while the channel is in ABOVE do not set the interrupt again.
- R8: The interrupt stays set until irq_clr is pulsed, and it clears one clock later. If a RISE occurs in the same cycle as the clear, the interrupt stays set.
- R9: The two channels are independent. Activity on one channel never changes the readback word or the interrupt of the other.
- R10: Without a sample strobe, the average and the threshold state hold, even while the sample data changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 2 | Per-channel sample strobe |
| smp_data | input | 20 | Per-channel 10-bit sample; channel c is at bits [10c+9:10c] |
| avg_code | input | 6 | Per-channel 3-bit depth code; channel c is at bits [3c+2:3c] |
| thr_hi | input | 20 | Per-channel 10-bit high threshold |
| irq_clr | input | 2 | Per-channel write-one-to-clear strobe for the interrupt |
| irq | output | 2 | Per-channel sticky interrupt |
| rdbk | output | 32 | Per-channel 16-bit readback word; channel c is at bits [16c+15:16c] |

## Verification
Two functions of a channel can fall in the same cycle: the interrupt clear and the setting of the interrupt by a sample. The bench provokes both orderings. In the first, a clear arrives with a sample that keeps the channel in ABOVE; the interrupt must drop, because that sample makes no RISE. In the second, a clear arrives with a sample that makes a RISE; the interrupt must stay set. Both cases are judged from the irq port and the readback word one clock after the shared edge.

// File: rtl/adcmon_pkg.sv
package adcmon_pkg;
    localparam int CODE_W   = 3;
    localparam int MAX_CODE = 5;

    typedef enum logic {
        ST_BELOW = 1'b0,
        ST_ABOVE = 1'b1
    } thr_state_e;

    function automatic logic [CODE_W-1:0] sat_code(input logic [CODE_W-1:0] c);
        return (c > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : c;
    endfunction
endpackage

// File: rtl/adcmon_avg.sv
module adcmon_avg
    import adcmon_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld,
    input  logic [CODE_W-1:0] code,
    input  logic [DATA_W-1:0] smp,
    output logic [DATA_W-1:0] avg_q,
    output logic [DATA_W-1:0] avg_nxt
);
    localparam int DW = DATA_W + 1;

    logic [CODE_W-1:0]  eff_code;
    logic signed [DW-1:0] diff;
    logic signed [DW-1:0] step;

    always_comb begin
        eff_code = sat_code(code);
        diff     = $signed({1'b0, smp}) - $signed({1'b0, avg_q});
        step     = diff >>> eff_code;
        avg_nxt  = avg_q + step[DATA_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            avg_q <= '0;
        else if (vld)
            avg_q <= avg_nxt;
    end

    // R10: no strobe, no change
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !vld |=> $stable(avg_q));

    // R2: code 0 takes the sample as is
    p_replace_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && code == '0) |=> avg_q == $past(smp));

    // R3: the new average lies between the old average and the sample
    p_between_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vld |=> (((avg_q >= $past(avg_q)) && (avg_q <= $past(smp))) ||
                 ((avg_q <= $past(avg_q)) && (avg_q >= $past(smp)))));
endmodule

// File: rtl/adcmon_thresh.sv
module adcmon_thresh
    import adcmon_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld,
    input  logic [DATA_W-1:0] val,
    input  logic [DATA_W-1:0] thr,
    input  logic              clr,
    output logic              above,
    output logic              irq_q
);
    thr_state_e st_q, st_nxt;
    logic       gt;
    logic       rise;

    // next-state and outputs
    always_comb begin
        gt     = (val > thr);
        st_nxt = st_q;
        rise   = 1'b0;
        unique case (st_q)
            ST_BELOW: begin
                if (vld && gt) begin
                    st_nxt = ST_ABOVE;
                    rise   = 1'b1;
                end
            end
            ST_ABOVE: begin
                if (vld && !gt)
                    st_nxt = ST_BELOW;
            end
            default: st_nxt = ST_BELOW;
        endcase
        above = (st_q == ST_ABOVE);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= ST_BELOW;
        else
            st_q <= st_nxt;
    end

    // sticky interrupt, set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else if (rise)
            irq_q <= 1'b1;
        else if (clr)
            irq_q <= 1'b0;
    end

    // R6: crossing from below sets the interrupt
    p_rise_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && !above && (val > thr)) |=> irq_q);

    // R7: staying above never re-raises a cleared interrupt
    p_no_retrig_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (above && !irq_q) |=> !irq_q);

    // R8: interrupt persists without a clear
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !clr) |=> irq_q);

    // R10: state only moves on a strobe
    p_state_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !vld |=> $stable(above));
endmodule

// File: rtl/adcmon_top.sv
module adcmon_top
    import adcmon_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int DATA_W = 10,
    parameter int RDBK_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCH-1:0]        smp_vld,
    input  logic [NCH*DATA_W-1:0] smp_data,
    input  logic [NCH*CODE_W-1:0] avg_code,
    input  logic [NCH*DATA_W-1:0] thr_hi,
    input  logic [NCH-1:0]        irq_clr,
    output logic [NCH-1:0]        irq,
    output logic [NCH*RDBK_W-1:0] rdbk
);
    localparam int PAD_W = RDBK_W - 1 - DATA_W;

    initial begin
        p_layout_r5: assert (PAD_W >= 0);
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [DATA_W-1:0] avg_q;
        logic [DATA_W-1:0] avg_nxt;
        logic              above;

        adcmon_avg #(.DATA_W(DATA_W)) u_avg (
            .clk     (clk),
            .rst_n   (rst_n),
            .vld     (smp_vld[c]),
            .code    (avg_code[c*CODE_W +: CODE_W]),
            .smp     (smp_data[c*DATA_W +: DATA_W]),
            .avg_q   (avg_q),
            .avg_nxt (avg_nxt)
        );

        adcmon_thresh #(.DATA_W(DATA_W)) u_thr (
            .clk   (clk),
            .rst_n (rst_n),
            .vld   (smp_vld[c]),
            .val   (avg_nxt),
            .thr   (thr_hi[c*DATA_W +: DATA_W]),
            .clr   (irq_clr[c]),
            .above (above),
            .irq_q (irq[c])
        );

        assign rdbk[c*RDBK_W +: RDBK_W] = {above, {PAD_W{1'b0}}, avg_q};

        // R9: an idle channel keeps its word and interrupt
        p_indep_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (!smp_vld[c] && !irq_clr[c]) |=> ($stable(rdbk[c*RDBK_W +: RDBK_W]) && $stable(irq[c])));
    end
endmodule

// File: tb/tb_adcmon_top.sv
module tb_adcmon_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  smp_vld;
    logic [19:0] smp_data;
    logic [5:0]  avg_code;
    logic [19:0] thr_hi;
    logic [1:0]  irq_clr;
    logic [1:0]  irq;
    logic [31:0] rdbk;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    adcmon_top dut (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
        .avg_code(avg_code), .thr_hi(thr_hi), .irq_clr(irq_clr),
        .irq(irq), .rdbk(rdbk)
    );

    // {code, sample, clr, exp_avg, exp_flag, exp_irq}; channel 0, threshold 200
    localparam logic [25:0] VEC [16] = '{
        {3'd0, 10'd100,  1'b0, 10'd100, 1'b0, 1'b0}, // R2
        {3'd0, 10'd300,  1'b0, 10'd300, 1'b1, 1'b1}, // R6 rise
        {3'd0, 10'd400,  1'b1, 10'd400, 1'b1, 1'b0}, // R8 clear, R7 no rise
        {3'd0, 10'd500,  1'b0, 10'd500, 1'b1, 1'b0}, // R7 no retrigger
        {3'd1, 10'd0,    1'b0, 10'd250, 1'b1, 1'b0}, // R3
        {3'd1, 10'd0,    1'b0, 10'd125, 1'b0, 1'b0}, // R3 fall
        {3'd2, 10'd1000, 1'b0, 10'd343, 1'b1, 1'b1}, // R3, R6
        {3'd2, 10'd1000, 1'b0, 10'd507, 1'b1, 1'b1}, // R8 sticky
        {3'd3, 10'd0,    1'b1, 10'd443, 1'b1, 1'b0}, // R3 floor, R8
        {3'd0, 10'd200,  1'b0, 10'd200, 1'b0, 1'b0}, // R7 equal is not above
        {3'd5, 10'd1023, 1'b1, 10'd225, 1'b1, 1'b1}, // R8 rise beats clear
        {3'd0, 10'd0,    1'b1, 10'd0,   1'b0, 1'b0}, // R8
        {3'd7, 10'd1023, 1'b0, 10'd31,  1'b0, 1'b0}, // R4
        {3'd6, 10'd1023, 1'b0, 10'd62,  1'b0, 1'b0}, // R4
        {3'd4, 10'd0,    1'b0, 10'd58,  1'b0, 1'b0}, // R3
        {3'd5, 10'd0,    1'b0, 10'd56,  1'b0, 1'b0}  // R3
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle();
        smp_vld = '0;
        irq_clr = '0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        idle();
        smp_data = '0;
        avg_code = '0;
        thr_hi   = {10'd50, 10'd200};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rdbk", rdbk, 32'h0);
        chk("R1 irq", {30'd0, irq}, 32'h0);

        for (int i = 0; i < 16; i++) begin
            logic [25:0] v;
            v = VEC[i];
            smp_vld        = 2'b01;
            avg_code[2:0]  = v[25:23];
            smp_data[9:0]  = v[22:13];
            irq_clr        = {1'b0, v[12]};
            @(negedge clk);
            idle();
            chk($sformatf("R5 vec%0d rdbk0", i), {16'd0, rdbk[15:0]},
                {16'd0, v[1], 5'd0, v[11:2]});
            chk($sformatf("R6 vec%0d irq0", i), {31'd0, irq[0]}, {31'd0, v[0]});
            chk($sformatf("R9 vec%0d ch1 idle", i), {15'd0, irq[1], rdbk[31:16]}, 32'h0);
        end

        // R10: data moves without strobe, average 56 holds
        smp_data[9:0] = 10'd999;
        avg_code[2:0] = 3'd0;
        repeat (3) @(negedge clk);
        chk("R10 hold", {16'd0, rdbk[15:0]}, 32'd56);

        // R8: clear with no pending interrupt keeps it low
        irq_clr = 2'b01;
        @(negedge clk);
        idle();
        chk("R8 idle clear", {31'd0, irq[0]}, 32'd0);

        // R9: channel 1 crosses its threshold of 50, channel 0 untouched
        smp_vld = 2'b10;
        avg_code[5:3]  = 3'd0;
        smp_data[19:10] = 10'd60;
        @(negedge clk);
        idle();
        chk("R9 ch1 rdbk", {16'd0, rdbk[31:16]}, {16'd0, 1'b1, 5'd0, 10'd60});
        chk("R9 ch1 irq", {31'd0, irq[1]}, 32'd1);
        chk("R9 ch0 rdbk", {16'd0, rdbk[15:0]}, 32'd56);
        chk("R9 ch0 irq", {31'd0, irq[0]}, 32'd0);

        // R8: clear channel 1 only; one clock later it drops
        irq_clr = 2'b10;
        @(negedge clk);
        idle();
        chk("R8 ch1 clear", {30'd0, irq}, 32'd0);

        // R1: reset in mid-run clears everything
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rerun rdbk", rdbk, 32'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule